// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire PHY management bus from a small word-addressed register file. Software picks an MDC division ratio with a 4-bit code and chooses whether frames carry the 32-bit all-ones preamble. It then loads the PHY and register numbers. A register write sends a Clause 22 write frame. A command bit starts a single read frame. A second command bit starts an auto-poll loop that reads the same PHY register over and over and refreshes the result register after each frame.

MDC is made by dividing the system clock and stays low between frames. The master drives MDIO through a separate output and output-enable pair. It releases the line for the whole turnaround and data phase of a read. It samples the input pin on MDC rising edges. A flag register shows whether a frame is on the wire, whether auto-poll is running, and whether the result register is still stale. A self-clearing bit in the configuration register stops the engine at once.

Top module: `mdio_master`

## Requirements
- R1: Configuration bits [3:0] select the MDC period in system clocks. Codes 0..15 give 2, 4, 6, 8, 10, 14, 20, 28, 16, 32, 48, 64, 80, 112, 160 and 224. The MDC high and low halves are equal, and MDC is low whenever no frame is active.
- R2: Writing any value to word 3 when the engine is idle sends a write frame carrying bits [15:0] of that value. The 32 frame bits go MSB first: 01, opcode 01, 5-bit PHY, 5-bit register, 10, then the 16 data bits.
- R3: When configuration bit 4 is 0, each frame is preceded by 32 driven ones, giving 64 MDC cycles per frame. When bit 4 is 1, the frame starts directly with 01 and takes 32 MDC cycles.
- R4: Writing word 1 with bit 0 set when idle sends a read frame with opcode 10. The master drives only the first 14 frame bits and keeps the output-enable low for the final 18 bit times. The last 16 bits sampled become bits [15:0] of word 4, MSB first.
- R5: In word 5, bit 0 is busy, bit 1 is scan and bit 2 is not-valid. Busy is 1 from a frame's start until its last bit has been clocked. Not-valid is 1 from the start of a read or scan until the result is latched.
- R6: Writing word 1 with bit 1 set when idle starts back-to-back read frames, and each frame refreshes word 4. Writing word 1 with bit 1 clear lets the current frame finish. After that the scan flag drops and no further MDC edges occur.
- R7: Writing word 0 with bit 31 set aborts any frame in the next cycle. It clears busy, scan and not-valid, and returns MDC and the output-enable low. Bit 31 reads back as 0.
- R8: Any start request (a word 3 write, or a word 1 write with bit 0 or bit 1 set) made while a frame is active or scanning is ignored. It launches no frame and does not change the data being sent.
- R9: Word 2 holds the PHY address in bits [12:8] and the register number in bits [4:0]. Other bits read as 0. Word 0 reads back the code and the preamble bit.
- R10: MDIO output changes only on the system cycle in which MDC falls, or at frame start while MDC is low. The input is sampled on the cycle in which MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered one cycle after reg_addr |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data out |
| mdo_oe | output | 1 | Output-enable for mdo |
| mdi | input | 1 | Management data in |

## Verification
The hardest case to reach is the end of an auto-poll loop. The stop request has to land while a frame is on the wire. The bench must then show three things: the frame still completes, the scan flag drops after it, and MDC stays quiet afterwards.

The bench runs scans at the fastest divider. A PHY model in the bench changes its answer mid-scan, so the bench can see the result register refresh. The stop is issued and the flags are polled until scan clears. The bench then counts MDC rising edges over a long idle window.

Aborting a long preamble frame and making start attempts during an active frame cover the other hard-to-reach states.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    SEL_CFG  = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_ADR  = 3'd2,
    SEL_WDAT = 3'd3,
    SEL_RDAT = 3'd4,
    SEL_FLAG = 3'd5
  } reg_sel_e;

  // Half of the MDC period in system clocks for each divider code.
  function automatic logic [6:0] half_period(input logic [3:0] code);
    logic [6:0] h;
    case (code)
      4'd0:  h = 7'd1;
      4'd1:  h = 7'd2;
      4'd2:  h = 7'd3;
      4'd3:  h = 7'd4;
      4'd4:  h = 7'd5;
      4'd5:  h = 7'd7;
      4'd6:  h = 7'd10;
      4'd7:  h = 7'd14;
      4'd8:  h = 7'd8;
      4'd9:  h = 7'd16;
      4'd10: h = 7'd24;
      4'd11: h = 7'd32;
      4'd12: h = 7'd40;
      4'd13: h = 7'd56;
      4'd14: h = 7'd80;
      default: h = 7'd112;
    endcase
    return h;
  endfunction

  // 32-bit Clause 22 frame body, MSB first on the wire.
  function automatic logic [31:0] build_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] regn, input logic [15:0] wd);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, regn, (rd ? 2'b11 : 2'b10),
            (rd ? 16'hFFFF : wd)};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [3:0] code,
  output logic       mdc,
  output logic       rise_tick,
  output logic       fall_tick
);
  import mdio_pkg::*;

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_m1;
  logic              tick;

  always_comb begin
    half_m1   = HALF_W'(half_period(code)) - HALF_W'(1);
    tick      = run && (cnt == half_m1);
    rise_tick = tick && !mdc;
    fall_tick = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PRE_LEN    = 32,
  parameter int FRAME_BITS = 32,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  logic              start_rd,
  input  logic              no_pre,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdi,
  output logic              active,
  output logic              is_rd,
  output logic              mdo,
  output logic              mdo_oe,
  output logic              fin,
  output logic [DATA_W-1:0] rx_data
);
  localparam int TOT     = PRE_LEN + FRAME_BITS;
  localparam int CW      = $clog2(TOT);
  localparam int REL_LEN = DATA_W + 2;

  logic [TOT-1:0] tx;
  logic [CW-1:0]  cnt;

  assign mdo = tx[TOT-1];
  assign fin = active && fall_tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active  <= 1'b0;
      is_rd   <= 1'b0;
      tx      <= '0;
      cnt     <= '0;
      mdo_oe  <= 1'b0;
      rx_data <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      is_rd  <= start_rd;
      mdo_oe <= 1'b1;
      if (no_pre) begin
        tx  <= {frame, {PRE_LEN{1'b0}}};
        cnt <= CW'(FRAME_BITS - 1);
      end else begin
        tx  <= {{PRE_LEN{1'b1}}, frame};
        cnt <= CW'(TOT - 1);
      end
    end else if (active) begin
      if (rise_tick && is_rd && (cnt < CW'(DATA_W)))
        rx_data <= {rx_data[DATA_W-2:0], mdi};
      if (fall_tick) begin
        if (cnt == '0) begin
          active <= 1'b0;
          mdo_oe <= 1'b0;
          tx     <= '0;
        end else begin
          tx     <= {tx[TOT-2:0], 1'b0};
          cnt    <= cnt - CW'(1);
          mdo_oe <= !(is_rd && (cnt <= CW'(REL_LEN)));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int BUS_W   = 32,
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdo,
  output logic             mdo_oe,
  input  logic             mdi
);
  import mdio_pkg::*;

  localparam int FRAME_BITS = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int PHY_LSB    = 8;

  logic [3:0]        cfg_code;
  logic              cfg_nopre;
  logic [ADDR_W-1:0] adr_phy, adr_reg;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              scan_req, scan_flag, flag_nv;

  logic eng_active, eng_rd, eng_fin, rise_tick, fall_tick;
  logic [DATA_W-1:0] eng_rx;
  logic mgmt_rst, idle, go_wr, go_rd, go_scan, restart, eng_start, eng_start_rd;
  logic wr_cfg, wr_cmd, wr_adr, wr_wdat;
  logic [FRAME_BITS-1:0] frame;

  always_comb begin
    wr_cfg   = reg_wr && (reg_addr == SEL_CFG);
    wr_cmd   = reg_wr && (reg_addr == SEL_CMD);
    wr_adr   = reg_wr && (reg_addr == SEL_ADR);
    wr_wdat  = reg_wr && (reg_addr == SEL_WDAT);
    mgmt_rst = wr_cfg && reg_wdata[BUS_W-1];
    idle     = !eng_active && !scan_flag;
    go_scan  = wr_cmd && reg_wdata[1] && idle;
    go_rd    = wr_cmd && reg_wdata[0] && !reg_wdata[1] && idle;
    go_wr    = wr_wdat && idle;
    restart  = scan_flag && scan_req && !eng_active && !mgmt_rst;
    eng_start    = go_wr || go_rd || go_scan || restart;
    eng_start_rd = !go_wr;
    frame = build_frame(eng_start_rd, adr_phy, adr_reg,
                        go_wr ? reg_wdata[DATA_W-1:0] : wdat_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_code  <= '0;
      cfg_nopre <= 1'b0;
      adr_phy   <= '0;
      adr_reg   <= '0;
      wdat_q    <= '0;
      rdat_q    <= '0;
      scan_req  <= 1'b0;
      scan_flag <= 1'b0;
      flag_nv   <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_code  <= reg_wdata[3:0];
        cfg_nopre <= reg_wdata[4];
      end
      if (wr_adr) begin
        adr_phy <= reg_wdata[PHY_LSB +: ADDR_W];
        adr_reg <= reg_wdata[0 +: ADDR_W];
      end
      if (go_wr) wdat_q <= reg_wdata[DATA_W-1:0];

      if (mgmt_rst) begin
        scan_req  <= 1'b0;
        scan_flag <= 1'b0;
        flag_nv   <= 1'b0;
      end else begin
        if (go_scan) scan_req <= 1'b1;
        else if (wr_cmd && !reg_wdata[1]) scan_req <= 1'b0;

        if (go_scan) scan_flag <= 1'b1;
        else if (scan_flag && !scan_req && (eng_fin || !eng_active)) scan_flag <= 1'b0;

        if (go_rd || go_scan) flag_nv <= 1'b1;
        else if (eng_fin && eng_rd) flag_nv <= 1'b0;

        if (eng_fin && eng_rd) rdat_q <= eng_rx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        SEL_CFG:  reg_rdata <= BUS_W'({cfg_nopre, cfg_code});
        SEL_CMD:  reg_rdata <= BUS_W'({scan_req, 1'b0});
        SEL_ADR:  reg_rdata <= BUS_W'({adr_phy, {(PHY_LSB-ADDR_W){1'b0}}, adr_reg});
        SEL_WDAT: reg_rdata <= BUS_W'(wdat_q);
        SEL_RDAT: reg_rdata <= BUS_W'(rdat_q);
        SEL_FLAG: reg_rdata <= BUS_W'({flag_nv, scan_flag, eng_active});
        default:  reg_rdata <= '0;
      endcase
    end
  end

  mdio_clkgen #(.HALF_W(7)) u_clk (
    .clk(clk), .rst(rst), .run(eng_active), .code(cfg_code),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN), .FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .abort(mgmt_rst), .start(eng_start), .start_rd(eng_start_rd),
    .no_pre(cfg_nopre), .frame(frame), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdi(mdi), .active(eng_active), .is_rd(eng_rd), .mdo(mdo), .mdo_oe(mdo_oe),
    .fin(eng_fin), .rx_data(eng_rx)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdo,
  input logic mdo_oe,
  input logic busy,
  input logic nv,
  input logic scan,
  input logic mrst
);
  a_r1_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !mdc);
  a_r10_mdo_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $stable(mdo));
  a_r4_oe_needs_busy: assert property (@(posedge clk) disable iff (rst)
    mdo_oe |-> busy);
  a_r5_nv_needs_busy: assert property (@(posedge clk) disable iff (rst)
    nv |-> busy);
  a_r7_abort_clears: assert property (@(posedge clk) disable iff (rst)
    mrst |=> (!busy && !nv && !scan && !mdo_oe));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe),
  .busy(eng_active), .nv(flag_nv), .scan(scan_flag), .mrst(mgmt_rst)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdo, mdo_oe;
  logic        mdi = 1'b1;

  int n_chk = 0, n_bad = 0;

  always #5 clk = !clk;

  mdio_master dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
  );

  // Bench-side PHY model and wire monitor, all at the falling system edge.
  logic [63:0] capbits = '0;
  int nrise = 0, ncap = 0, relbits = 0, ncyc = 0, last_rise = 0, per = 0;
  logic        prev_mdc = 1'b0;
  logic [15:0] phy_data = 16'h0000;

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (mdc && !prev_mdc) begin
      per = ncyc - last_rise;
      last_rise = ncyc;
      nrise = nrise + 1;
      if (mdo_oe) begin
        capbits = {capbits[62:0], mdo};
        ncap = ncap + 1;
        relbits = 0;
      end else relbits = relbits + 1;
    end
    prev_mdc = mdc;
    if (relbits == 0) mdi = 1'b1;
    else if (relbits == 1) mdi = 1'b0;
    else if (relbits <= 17) mdi = phy_data[17 - relbits];
    else mdi = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] f;
    for (int i = 0; i < 40000; i++) begin
      rd(3'd5, f);
      if (f[2:0] == 3'b000) break;
    end
  endtask

  function automatic logic [31:0] frame_of(input logic r, input logic [4:0] p,
                                           input logic [4:0] g, input logic [15:0] d);
    return {2'b01, (r ? 2'b10 : 2'b01), p, g, (r ? 2'b11 : 2'b10), d};
  endfunction

  // {code, period, read, preamble, phy, reg, data}
  localparam logic [39:0] VEC [16] = '{
    {4'd0,  8'd2,   1'b0, 1'b1, 5'd1,  5'd2,  16'hA5C3},
    {4'd1,  8'd4,   1'b1, 1'b0, 5'd3,  5'd1,  16'h1234},
    {4'd2,  8'd6,   1'b0, 1'b0, 5'd31, 5'd31, 16'hFFFF},
    {4'd3,  8'd8,   1'b1, 1'b1, 5'd0,  5'd0,  16'h8001},
    {4'd4,  8'd10,  1'b0, 1'b0, 5'd16, 5'd8,  16'h0000},
    {4'd5,  8'd14,  1'b1, 1'b0, 5'd5,  5'd17, 16'hBEEF},
    {4'd6,  8'd20,  1'b0, 1'b1, 5'd9,  5'd4,  16'h5A5A},
    {4'd7,  8'd28,  1'b1, 1'b0, 5'd21, 5'd10, 16'hC0DE},
    {4'd8,  8'd16,  1'b0, 1'b0, 5'd2,  5'd30, 16'h7F80},
    {4'd9,  8'd32,  1'b1, 1'b1, 5'd12, 5'd6,  16'h0F0F},
    {4'd10, 8'd48,  1'b0, 1'b0, 5'd7,  5'd7,  16'h3C3C},
    {4'd11, 8'd64,  1'b1, 1'b0, 5'd28, 5'd3,  16'h9999},
    {4'd12, 8'd80,  1'b0, 1'b1, 5'd14, 5'd12, 16'h4321},
    {4'd13, 8'd112, 1'b1, 1'b0, 5'd19, 5'd25, 16'hE00E},
    {4'd14, 8'd160, 1'b0, 1'b1, 5'd27, 5'd14, 16'h0001},
    {4'd15, 8'd224, 1'b1, 1'b1, 5'd11, 5'd21, 16'h6B6B}
  };

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base_r, base_c;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    rd(3'd5, r); check(r == 0, "R5 reset flags", r, 0);
    rd(3'd0, r); check(r == 0, "R9 reset cfg", r, 0);
    check(!mdc && !mdo_oe, "R1 reset pins", {mdc, mdo_oe}, 0);

    // Table walk over every divider code
    foreach (VEC[k]) begin
      logic [39:0] v;
      logic [31:0] f;
      v = VEC[k];
      wr(3'd0, {27'd0, !v[26], v[39:36]});
      wr(3'd2, {19'd0, v[25:21], 3'd0, v[20:16]});
      phy_data = v[15:0];
      base_r = nrise; base_c = ncap;
      if (v[27]) wr(3'd1, 32'd1); else wr(3'd3, {16'd0, v[15:0]});
      if (v[27]) begin
        rd(3'd5, r); check(r[2:0] == 3'b101, "R5 read flags", r, 5);
      end
      wait_idle();
      check(per == int'(v[35:28]), "R1 mdc period", per, v[35:28]);
      check(nrise - base_r == (v[26] ? 64 : 32), "R3 frame length", nrise - base_r,
            v[26] ? 64 : 32);
      f = frame_of(v[27], v[25:21], v[20:16], v[15:0]);
      if (!v[27]) begin
        if (v[26]) check(capbits == {32'hFFFF_FFFF, f}, "R2 write frame with preamble",
                         capbits, {32'hFFFF_FFFF, f});
        else check(capbits[31:0] == f, "R2 write frame bits", capbits[31:0], f);
      end else begin
        check(ncap - base_c == (v[26] ? 46 : 14), "R4 driven bit count", ncap - base_c,
              v[26] ? 46 : 14);
        check(capbits[13:0] == f[31:18], "R4 read header", capbits[13:0], f[31:18]);
        rd(3'd4, r); check(r == {16'd0, v[15:0]}, "R4 read data", r, v[15:0]);
      end
      rd(3'd5, r); check(r == 0, "R5 flags after frame", r, 0);
    end

    // R9 address fields and readback masking
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, r); check(r == 32'h1F1F, "R9 address readback", r, 32'h1F1F);

    // R8 start requests during an active write are ignored
    wr(3'd0, 32'h0000_0013);
    wr(3'd2, {19'd0, 5'd6, 3'd0, 5'd9});
    base_r = nrise;
    wr(3'd3, 32'h0000_1111);
    wr(3'd3, 32'h0000_2222);
    wr(3'd1, 32'h0000_0001);
    rd(3'd5, r); check(r[2:0] == 3'b001, "R8 read start ignored", r, 1);
    wait_idle();
    check(capbits[31:0] == frame_of(1'b0, 5'd6, 5'd9, 16'h1111), "R8 data unchanged",
          capbits[31:0], frame_of(1'b0, 5'd6, 5'd9, 16'h1111));
    check(nrise - base_r == 32, "R8 single frame", nrise - base_r, 32);

    // R6 scan: repeated reads, refresh, graceful stop
    wr(3'd0, 32'h0000_0010);
    phy_data = 16'hAAAA;
    wr(3'd1, 32'h0000_0002);
    rd(3'd5, r); check(r[2:0] == 3'b111, "R6 scan flags", r, 7);
    for (int i = 0; i < 200; i++) begin rd(3'd5, r); if (!r[2]) break; end
    rd(3'd4, r); check(r == 32'hAAAA, "R6 first scan result", r, 32'hAAAA);
    phy_data = 16'h5555;
    for (int i = 0; i < 400; i++) begin rd(3'd4, r); if (r == 32'h5555) break; end
    check(r == 32'h5555, "R6 scan refresh", r, 32'h5555);
    wr(3'd1, 32'h0000_0000);
    rd(3'd5, r); check(r[1] == 1'b1, "R6 scan held until frame end", r, 2);
    for (int i = 0; i < 400; i++) begin rd(3'd5, r); if (r[1:0] == 0) break; end
    check(r[2:0] == 0, "R6 scan stopped", r, 0);
    base_r = nrise;
    repeat (500) @(negedge clk);
    check(nrise == base_r, "R6 no frames after stop", nrise - base_r, 0);

    // R7 abort in the middle of a long preamble frame
    wr(3'd0, 32'h0000_000F);
    wr(3'd3, 32'h0000_ABCD);
    repeat (2000) @(negedge clk);
    wr(3'd0, 32'h8000_000F);
    rd(3'd5, r); check(r == 0, "R7 flags cleared", r, 0);
    check(!mdc && !mdo_oe, "R7 pins idle", {mdc, mdo_oe}, 0);
    rd(3'd0, r); check(r == 32'h0F, "R7 bit31 self clears", r, 32'h0F);
    base_r = nrise;
    repeat (600) @(negedge clk);
    check(nrise == base_r, "R7 no edges after abort", nrise - base_r, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule